// File: doc/BRIEF.md
# Biphase-Mark Subframe Receiver

This block takes a single-wire serial audio line, sampled by a fast local oversampling clock, and turns it into 32-bit subframe words. Clock and data travel together on the line in biphase-mark form. Every bit cell opens with a transition, and a one carries a second transition in the middle of the cell. The receiver does not need to know the bit rate in advance. It measures the time between edges in oversampling-clock counts and takes the shortest interval it has seen as the half-cell length. It then sorts every later interval into one, two or three half-cells.

A subframe is 32 slots long. The first four slots hold a synchronisation pattern that contains a three-half-cell pulse, which ordinary data can never produce. Three such patterns are recognised. One marks channel A of the first frame of a block. One marks channel A of any other frame. One marks channel B. The remaining 28 slots hold the audio sample of up to 24 bits, followed by the validity, user, channel-status and parity slots. Each well-formed subframe is presented for one cycle together with its channel, a block-start flag, the index of its frame within the block and a parity-error flag. A lock indicator tells downstream logic when the stream can be trusted.

Top module: `bmc_subframe_rx`

## Requirements
- R1: After reset, `sf_valid`, `locked` and `sf_word` are all zero.
- R2: A bit cell with a single transition decodes as 0, and one with a mid-cell transition decodes as 1. In `sf_word`, bit i holds slot i for i from 4 to 31, where slot 4 is the first cell after the four-slot preamble. Bits 3 to 0 are zero.
- R3: The half-cell length is taken from the shortest edge interval seen. After a loss of lock it is learned again, so a stream at a different rate decodes correctly once a stream at the first rate has stopped.
- R4: The preamble is classified by its pulse lengths in half-cells. The sequence 3-1-1-3 gives block start (`sf_blk_start`=1, `sf_chan_b`=0). The sequence 3-3-1-1 gives channel A (`sf_chan_b`=0). The sequence 3-2-1-2 gives channel B (`sf_chan_b`=1).
- R5: `sf_frame` is 0 on a block-start subframe. Each channel A subframe advances it by one, and it wraps from BLOCK_FRAMES-1 to 0 even when no block start arrives. A channel B subframe carries the index of the channel A subframe before it.
- R6: A subframe whose preamble matches none of the three patterns produces no `sf_valid` pulse, and the subframes after it are still decoded.
- R7: `sf_parity_err` is 1 exactly when slots 4 to 31 of the subframe hold an odd number of ones.
- R8: `locked` rises together with the `sf_valid` pulse of the second of two consecutive well-formed subframes. A malformed subframe restarts that count but does not clear `locked`.
- R9: `locked` falls once no transition has arrived for four half-cells, which is two cell times.
- R10: `sf_valid` is a single-cycle pulse, and every subframe output holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Raw biphase-mark line, asynchronous to clk |
| sf_word | output | 32 | Decoded subframe: slots 4..31 in bits 4..31, zeros below |
| sf_valid | output | 1 | One-cycle strobe for a new subframe |
| sf_chan_b | output | 1 | Subframe belongs to channel B |
| sf_blk_start | output | 1 | Subframe is channel A of block frame 0 |
| sf_frame | output | FIDX_W | Frame index within the block |
| sf_parity_err | output | 1 | Odd number of ones in slots 4..31 |
| locked | output | 1 | Stream is being tracked |

## Verification
The bench sets BLOCK_FRAMES to 4, so that a whole block and its wrap back to frame 0 without a block-start preamble both happen within a few dozen subframes. CNT_W stays at 8, so the idle gap between the two bursts runs the edge counter into saturation. The first burst uses four oversampling clocks per half-cell and the second uses five. Between them, timeout, loss of lock, relearning of the cell length and a fresh lock all occur in one short run.

// File: rtl/bmc_rx_pkg.sv
// Shared types for the biphase-mark subframe receiver.
// Assumes: a subframe is 32 slots with a 4-slot preamble in front.
package bmc_rx_pkg;

    // Length class of one interval between line transitions
    typedef enum logic [1:0] {
        PW_HALF = 2'd0,   // one half-cell
        PW_FULL = 2'd1,   // two half-cells
        PW_LONG = 2'd2,   // three half-cells (preamble only)
        PW_BAD  = 2'd3    // anything else
    } pulse_e;

    // Preamble kind
    typedef enum logic [1:0] {
        PT_BLOCK = 2'd0,
        PT_CHA   = 2'd1,
        PT_CHB   = 2'd2,
        PT_NONE  = 2'd3
    } pre_e;

    localparam int SF_SLOTS   = 32;
    localparam int PRE_SLOTS  = 4;
    localparam int DATA_SLOTS = SF_SLOTS - PRE_SLOTS;

endpackage

// File: rtl/bmc_edge_timer.sv
// Synchronises the raw line, detects transitions and counts the
// oversampling-clock cycles since the last transition.
// Assumes: line idles low out of reset; the count saturates at all-ones.
module bmc_edge_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic             edge_any,
    output logic             edge_vld,
    output logic [CNT_W-1:0] run_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [2:0] sync_q;
    logic       seen_q;

    assign edge_any = sync_q[2] ^ sync_q[1];
    assign edge_vld = edge_any & seen_q;

    // Two-flop synchroniser plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], line_in};
    end

    // Marks that at least one transition opened an interval
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (edge_any) seen_q <= 1'b1;
    end

    // Interval counter, restarts at each transition and saturates
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (edge_any)       run_cnt <= CNT_W'(1);
        else if (run_cnt != CMAX) run_cnt <= run_cnt + CNT_W'(1);
    end

endmodule

// File: rtl/bmc_pulse_classifier.sv
// Learns the half-cell length as the shortest interval between edges and
// sorts each interval into one, two or three half-cells. Raises a timeout
// when the line stays quiet for four half-cells; that forgets the length.
// Assumes: intervals arrive from bmc_edge_timer; saturated ones are bad.
module bmc_pulse_classifier
    import bmc_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_any,
    input  logic             edge_vld,
    input  logic [CNT_W-1:0] run_cnt,
    output logic             pulse_vld,
    output pulse_e           pulse_cls,
    output logic             timeout
);
    localparam int               W    = CNT_W + 3;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] short_q;
    logic [CNT_W-1:0] eff;
    logic [W-1:0]     len2_w;
    logic [W-1:0]     eff_w;
    logic             sat;
    logic             tmo_hit;
    pulse_e           cls_c;

    assign sat    = (run_cnt == CMAX);
    assign eff    = (run_cnt < short_q) ? run_cnt : short_q;
    assign len2_w = W'(run_cnt) << 1;
    assign eff_w  = W'(eff);

    // Threshold the interval at 1.5, 2.5 and 3.5 half-cells
    always_comb begin
        if (sat)                              cls_c = PW_BAD;
        else if (len2_w < eff_w * W'(3))      cls_c = PW_HALF;
        else if (len2_w < eff_w * W'(5))      cls_c = PW_FULL;
        else if (len2_w < eff_w * W'(7))      cls_c = PW_LONG;
        else                                  cls_c = PW_BAD;
    end

    // Quiet for four half-cells while a length is known
    assign tmo_hit = !edge_any && (short_q != CMAX) &&
                     (W'(run_cnt) == (W'(short_q) << 2));

    // Track the shortest interval; forget it on timeout
    always_ff @(posedge clk) begin
        if (!rst_n)                                   short_q <= CMAX;
        else if (tmo_hit)                             short_q <= CMAX;
        else if (edge_vld && !sat && run_cnt < short_q) short_q <= run_cnt;
    end

    // Register the classified pulse and the timeout event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_vld <= 1'b0;
            pulse_cls <= PW_BAD;
            timeout   <= 1'b0;
        end else begin
            pulse_vld <= edge_vld;
            pulse_cls <= cls_c;
            timeout   <= tmo_hit;
        end
    end

endmodule

// File: rtl/bmc_subframe_decoder.sv
// Turns the stream of classified pulses into preambles and data bits and
// assembles 28 data slots per subframe. Reports each good subframe and
// each subframe that broke off.
// Assumes: a three-half-cell pulse only ever opens a preamble.
module bmc_subframe_decoder
    import bmc_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pulse_vld,
    input  pulse_e                pulse_cls,
    input  logic                  flush,
    output logic                  sf_good,
    output logic                  sf_bad,
    output logic [DATA_SLOTS-1:0] sf_data,
    output pre_e                  sf_type
);
    localparam int               BI_W     = $clog2(DATA_SLOTS);
    localparam logic [BI_W-1:0]  LAST_BIT = BI_W'(DATA_SLOTS - 1);

    typedef enum logic [1:0] {ST_HUNT, ST_PRE, ST_DATA, ST_NEXT} st_e;

    st_e                   state;
    logic [1:0]            pre_cnt;
    logic [3:0]            pre_code;
    logic                  half_pend;
    logic [BI_W-1:0]       bit_idx;
    logic [DATA_SLOTS-2:0] data_q;
    pre_e                  match;
    logic                  bit_done;
    logic                  bit_val;
    logic                  data_err;

    // Compare the three pulses after the opening long pulse
    always_comb begin
        unique case ({pre_code, pulse_cls})
            {PW_HALF, PW_HALF, PW_LONG}: match = PT_BLOCK;
            {PW_LONG, PW_HALF, PW_HALF}: match = PT_CHA;
            {PW_FULL, PW_HALF, PW_FULL}: match = PT_CHB;
            default:                     match = PT_NONE;
        endcase
    end

    // Biphase-mark bit decision inside the data field
    always_comb begin
        bit_done = 1'b0;
        bit_val  = 1'b0;
        data_err = 1'b0;
        if (state == ST_DATA) begin
            unique case (pulse_cls)
                PW_FULL: begin bit_done = !half_pend; data_err = half_pend; end
                PW_HALF: begin bit_done = half_pend;  bit_val  = 1'b1;      end
                default: data_err = 1'b1;
            endcase
        end
    end

    // Framing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            pre_cnt   <= '0;
            pre_code  <= '0;
            half_pend <= 1'b0;
            bit_idx   <= '0;
            data_q    <= '0;
            sf_good   <= 1'b0;
            sf_bad    <= 1'b0;
            sf_data   <= '0;
            sf_type   <= PT_NONE;
        end else begin
            sf_good <= 1'b0;
            sf_bad  <= 1'b0;
            if (flush) begin
                state <= ST_HUNT;
            end else if (pulse_vld) begin
                unique case (state)
                    ST_HUNT: begin
                        if (pulse_cls == PW_LONG) begin
                            state   <= ST_PRE;
                            pre_cnt <= '0;
                        end
                    end
                    ST_NEXT: begin
                        pre_cnt <= '0;
                        if (pulse_cls == PW_LONG) state <= ST_PRE;
                        else begin
                            state  <= ST_HUNT;
                            sf_bad <= 1'b1;
                        end
                    end
                    ST_PRE: begin
                        pre_code <= {pre_code[1:0], pulse_cls};
                        if (pre_cnt == 2'd2) begin
                            pre_cnt <= '0;
                            if (match != PT_NONE) begin
                                state     <= ST_DATA;
                                sf_type   <= match;
                                half_pend <= 1'b0;
                                bit_idx   <= '0;
                            end else begin
                                sf_bad <= 1'b1;
                                state  <= (pulse_cls == PW_LONG) ? ST_PRE : ST_HUNT;
                            end
                        end else begin
                            pre_cnt <= pre_cnt + 2'd1;
                        end
                    end
                    ST_DATA: begin
                        if (data_err) begin
                            sf_bad  <= 1'b1;
                            pre_cnt <= '0;
                            state   <= (pulse_cls == PW_LONG) ? ST_PRE : ST_HUNT;
                        end else if (!bit_done) begin
                            half_pend <= 1'b1;
                        end else begin
                            half_pend <= 1'b0;
                            if (bit_idx == LAST_BIT) begin
                                sf_data <= {bit_val, data_q};
                                sf_good <= 1'b1;
                                state   <= ST_NEXT;
                            end else begin
                                data_q[bit_idx] <= bit_val;
                                bit_idx         <= bit_idx + BI_W'(1);
                            end
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/bmc_subframe_rx.sv
// Top of the biphase-mark subframe receiver: edge timing, pulse
// classification, framing, frame counting and lock tracking.
// Assumes: clk is at least a few times the half-cell rate; no software
// control, every output is registered.
module bmc_subframe_rx
    import bmc_rx_pkg::*;
#(
    parameter  int BLOCK_FRAMES = 192,
    parameter  int CNT_W        = 8,
    localparam int FIDX_W       = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic [31:0]       sf_word,
    output logic              sf_valid,
    output logic              sf_chan_b,
    output logic              sf_blk_start,
    output logic [FIDX_W-1:0] sf_frame,
    output logic              sf_parity_err,
    output logic              locked
);
    localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(BLOCK_FRAMES - 1);

    logic                  edge_any;
    logic                  edge_vld;
    logic [CNT_W-1:0]      run_cnt;
    logic                  pulse_vld;
    pulse_e                pulse_cls;
    logic                  timeout;
    logic                  dec_good;
    logic                  dec_bad;
    logic [DATA_SLOTS-1:0] dec_data;
    pre_e                  dec_type;
    logic                  good_run;
    logic [FIDX_W-1:0]     frame_nxt;

    bmc_edge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .edge_any (edge_any),
        .edge_vld (edge_vld),
        .run_cnt  (run_cnt)
    );

    bmc_pulse_classifier #(.CNT_W(CNT_W)) u_class (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_any  (edge_any),
        .edge_vld  (edge_vld),
        .run_cnt   (run_cnt),
        .pulse_vld (pulse_vld),
        .pulse_cls (pulse_cls),
        .timeout   (timeout)
    );

    bmc_subframe_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_vld (pulse_vld),
        .pulse_cls (pulse_cls),
        .flush     (timeout),
        .sf_good   (dec_good),
        .sf_bad    (dec_bad),
        .sf_data   (dec_data),
        .sf_type   (dec_type)
    );

    // Frame index the incoming subframe belongs to
    always_comb begin
        unique case (dec_type)
            PT_BLOCK: frame_nxt = '0;
            PT_CHA:   frame_nxt = (sf_frame == LAST_FRAME) ? '0 : sf_frame + FIDX_W'(1);
            default:  frame_nxt = sf_frame;
        endcase
    end

    // Output register for each finished subframe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_valid      <= 1'b0;
            sf_word       <= '0;
            sf_chan_b     <= 1'b0;
            sf_blk_start  <= 1'b0;
            sf_frame      <= '0;
            sf_parity_err <= 1'b0;
        end else begin
            sf_valid <= dec_good;
            if (dec_good) begin
                sf_word       <= {dec_data, {PRE_SLOTS{1'b0}}};
                sf_chan_b     <= (dec_type == PT_CHB);
                sf_blk_start  <= (dec_type == PT_BLOCK);
                sf_frame      <= frame_nxt;
                sf_parity_err <= ^dec_data;
            end
        end
    end

    // Lock after two good subframes in a row; drop on a quiet line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            good_run <= 1'b0;
        end else if (timeout) begin
            locked   <= 1'b0;
            good_run <= 1'b0;
        end else if (dec_good) begin
            good_run <= 1'b1;
            if (good_run) locked <= 1'b1;
        end else if (dec_bad) begin
            good_run <= 1'b0;
        end
    end

endmodule

// File: rtl/bmc_subframe_rx_chk.sv
// Property checker for bmc_subframe_rx, attached with bind below.
// Assumes: subframes are many cycles apart.
module bmc_subframe_rx_chk #(
    parameter  int BLOCK_FRAMES = 192,
    localparam int FIDX_W       = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       sf_word,
    input logic              sf_valid,
    input logic              sf_chan_b,
    input logic              sf_blk_start,
    input logic [FIDX_W-1:0] sf_frame,
    input logic              locked
);
    // R10: strobe lasts one cycle
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid |=> !sf_valid);

    // R10: word only changes with a strobe
    p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_valid |-> $stable(sf_word));

    // R4 / R5: block start is channel A of frame 0
    p_blk_frame0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && sf_blk_start) |-> (sf_frame == '0 && !sf_chan_b));

    // R5: channel B keeps the index of its frame
    p_chb_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && sf_chan_b) |-> $stable(sf_frame));

    // R5: index stays inside the block
    p_frame_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sf_frame) < BLOCK_FRAMES);

    // R8: lock is gained only together with a subframe
    p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> sf_valid);

    // R9: lock is lost only while no subframe is delivered
    p_lock_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> !sf_valid);

endmodule

bind bmc_subframe_rx bmc_subframe_rx_chk #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sf_word      (sf_word),
    .sf_valid     (sf_valid),
    .sf_chan_b    (sf_chan_b),
    .sf_blk_start (sf_blk_start),
    .sf_frame     (sf_frame),
    .locked       (locked)
);

// File: tb/bmc_subframe_rx_bench.sv
// Self-checking bench: random payloads in two bursts at different rates,
// directed preamble corruption, parity errors, frame wrap and timeout.
module bmc_subframe_rx_bench;
    localparam int BF     = 4;
    localparam int FIDX_W = $clog2(BF);
    localparam int T_BLK  = 0;
    localparam int T_A    = 1;
    localparam int T_B    = 2;
    localparam int T_BAD  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_r = 1'b0;
    logic [31:0]       sf_word;
    logic              sf_valid;
    logic              sf_chan_b;
    logic              sf_blk_start;
    logic [FIDX_W-1:0] sf_frame;
    logic              sf_parity_err;
    logic              locked;

    int n_tests = 0;
    int n_fail  = 0;
    int hc      = 4;
    bit done    = 1'b0;

    logic [31:0] e_word [64];
    bit          e_b    [64];
    bit          e_blk  [64];
    int          e_fr   [64];
    bit          e_perr [64];
    bit          e_lock [64];
    int wr = 0;
    int rd = 0;
    int m_frame = 0;
    bit m_run = 1'b0;
    bit m_lock = 1'b0;

    always #4 clk = ~clk;

    bmc_subframe_rx #(.BLOCK_FRAMES(BF), .CNT_W(8)) u_bmc_subframe_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_r),
        .sf_word       (sf_word),
        .sf_valid      (sf_valid),
        .sf_chan_b     (sf_chan_b),
        .sf_blk_start  (sf_blk_start),
        .sf_frame      (sf_frame),
        .sf_parity_err (sf_parity_err),
        .locked        (locked)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int next_frame(input int t, input int cur);
        if (t == T_BLK) return 0;
        if (t == T_A)   return (cur + 1) % BF;
        return cur;
    endfunction

    task automatic pulse(input int halves);
        line_r = ~line_r;
        repeat (halves * hc) @(negedge clk);
    endtask

    // Sends one subframe; model=1 records what the receiver must report
    task automatic send_sf(input int t, input logic [27:0] d, input bit model);
        if (model) begin
            if (t == T_BAD) m_run = 1'b0;
            else begin
                m_frame = next_frame(t, m_frame);
                if (m_run) m_lock = 1'b1;
                m_run = 1'b1;
                e_word[wr] = {d, 4'b0000};
                e_b[wr]    = (t == T_B);
                e_blk[wr]  = (t == T_BLK);
                e_fr[wr]   = m_frame;
                e_perr[wr] = ^d;
                e_lock[wr] = m_lock;
                wr++;
            end
        end
        case (t)
            T_BLK:   begin pulse(3); pulse(1); pulse(1); pulse(3); end
            T_A:     begin pulse(3); pulse(3); pulse(1); pulse(1); end
            T_B:     begin pulse(3); pulse(2); pulse(1); pulse(2); end
            default: begin pulse(3); pulse(2); pulse(2); pulse(1); end
        endcase
        for (int i = 0; i < 28; i++) begin
            if (d[i]) begin pulse(1); pulse(1); end
            else pulse(2);
        end
    endtask

    function automatic logic [27:0] rand_payload(input bit bad_par);
        logic [26:0] p;
        p = 27'($urandom());
        return {(^p) ^ bad_par, p};
    endfunction

    // Monitor: compare every strobe with the next expected subframe
    always @(negedge clk) begin
        if (rst_n && sf_valid) begin
            if (rd >= wr) check(1'b0, "R6 unexpected subframe", longint'(sf_word), 0);
            else begin
                check(sf_word == e_word[rd], "R2 word", longint'(sf_word), longint'(e_word[rd]));
                check(sf_chan_b == e_b[rd], "R4 channel", longint'(sf_chan_b), longint'(e_b[rd]));
                check(sf_blk_start == e_blk[rd], "R4 block start", longint'(sf_blk_start), longint'(e_blk[rd]));
                check(int'(sf_frame) == e_fr[rd], "R5 frame index", longint'(sf_frame), longint'(e_fr[rd]));
                check(sf_parity_err == e_perr[rd], "R7 parity flag", longint'(sf_parity_err), longint'(e_perr[rd]));
                check(locked == e_lock[rd], "R8 lock", longint'(locked), longint'(e_lock[rd]));
                rd++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(sf_valid == 1'b0, "R1 valid", longint'(sf_valid), 0);
        check(locked == 1'b0, "R1 locked", longint'(locked), 0);
        check(sf_word == 32'd0, "R1 word", longint'(sf_word), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(sf_valid == 1'b0 && locked == 1'b0, "R1 idle line", longint'(locked), 0);

        // Burst 1: four clocks per half-cell
        hc = 4;
        m_run = 1'b0; m_lock = 1'b0;
        send_sf(T_A, rand_payload(1'b0), 1'b0);   // lets the cell length settle
        for (int k = 0; k < 16; k++) begin
            int t;
            logic [27:0] d;
            t = (k % 8 == 0) ? T_BLK : ((k % 2 == 1) ? T_B : T_A);
            d = rand_payload(($urandom() % 6) == 0);
            if (k == 1) d = 28'd0;                          // R2 all zeros
            if (k == 2) d = {1'b1, 27'h7FF_FFFF};           // R2 all ones
            if (k == 3) d = {1'b0, 27'h000_0001};           // R7 odd ones
            if (k == 5) t = T_BAD;                          // R6 corrupt preamble
            send_sf(t, d, 1'b1);
        end
        line_r = ~line_r;                                    // closes last cell
        repeat (10) @(negedge clk);
        check(rd == wr, "R6 burst 1 count", longint'(rd), longint'(wr));
        check(locked == 1'b1, "R8 lock held after malformed subframe", longint'(locked), 1);
        repeat (400) @(negedge clk);
        check(locked == 1'b0, "R9 lock after quiet line", longint'(locked), 0);

        // Burst 2: five clocks per half-cell, frame index wraps unaided
        hc = 5;
        m_run = 1'b0; m_lock = 1'b0;
        send_sf(T_A, rand_payload(1'b0), 1'b0);
        for (int k = 0; k < 12; k++) begin
            int t;
            t = (k == 0) ? T_BLK : ((k % 2 == 1) ? T_B : T_A);
            send_sf(t, rand_payload(($urandom() % 5) == 0), 1'b1);
        end
        line_r = ~line_r;
        repeat (12) @(negedge clk);
        check(rd == wr, "R3 burst 2 at new rate", longint'(rd), longint'(wr));
        check(locked == 1'b1, "R8 relock", longint'(locked), 1);
        repeat (400) @(negedge clk);
        check(locked == 1'b0, "R9 second timeout", longint'(locked), 0);
        check(sf_valid == 1'b0, "R10 no strobe when idle", longint'(sf_valid), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule